// File: doc/BRIEF.md
# Transport Stream Ring Capture Writer

This block captures a byte-serial MPEG transport stream into a circular buffer in system memory. Incoming bytes carry a valid strobe and a start strobe that marks the first byte of each packet. A two-state capture machine, HUNT and PACK, tracks packet framing. HUNT waits for a start byte and drops any other byte. PACK counts the bytes of the current packet. The transitions are named here. START moves HUNT to PACK on a start byte. LAST moves PACK back to HUNT when the programmed packet length is reached. RESYNC keeps the machine in PACK and restarts the byte count when a start byte arrives mid-packet. ABORT forces any state to HUNT when software restarts the ring. A start byte in HUNT that is also the last byte of a packet (packet length 1) completes the packet and stays in HUNT.

Accepted bytes are packed little-endian into 32-bit words. Lane packing runs continuously over accepted bytes, independent of packet boundaries. Each complete word goes out as one write on a simple word-write master port. Its address is the ring start address plus the current byte offset, and the offset wraps to zero at the ring length. Software programs the ring start address, ring length, packet length and packets-per-interrupt group size through a small register port. It reads an absolute write pointer and subtracts the start address to find the fill level. After each group of packets a status bit is set. This bit drives a maskable interrupt and is cleared by writing a one back to it.

Top module: `ts_ring_writer`

## Requirements
- R1: After reset the registers read: control (index 0) = 0, start address (index 1) = 0, ring length (index 2) = 120320, packet length (index 3) = 188, group size (index 4) = 47, write pointer (index 5) = 0, status (index 6) = 0, mask (index 7) = 0. The irq output and mem_we are 0.
- R2: Accepted bytes are packed little-endian: the first byte of a word goes in bits 7:0, the fourth in bits 31:24. One memory write happens per four accepted bytes, in the cycle after the fourth byte is sampled. Its address is start address plus byte offset, and the offset then advances by 4.
- R3: When offset+4 would reach or pass the ring length (index 2, in bytes), the offset returns to 0. No write address leaves [start, start+ring length).
- R4: Reading index 5 returns the absolute address start + offset of the next word to be written.
- R5: In HUNT only a byte with the start strobe is accepted. Bytes without it cause no write and no pointer movement.
- R6: A start byte in PACK begins a new packet with byte count 1 (RESYNC). The interrupted packet is never counted as complete.
- R7: Each packet of the programmed length (index 3) increments a packet counter. When the counter reaches the group size (index 4), status bit 0 (index 6) is set and the counter returns to 0.
- R8: irq is high exactly when status bit 0, mask bit 0 (index 7, 1 = enabled) and control bit 0 are all 1.
- R9: Writing index 6 with bit 0 = 1 clears status bit 0. Writing it with bit 0 = 0 has no effect.
- R10: Writing index 8 with bit 0 = 1 returns the write pointer to the start address, clears partial word and packet count, and forces HUNT (ABORT). A byte arriving in that cycle is dropped.
- R11: While control bit 0 is 0, input bytes cause no write, no pointer change and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| ts_valid | input | 1 | Stream byte valid |
| ts_start | input | 1 | First byte of a packet |
| ts_data | input | 8 | Stream byte |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Memory word data |
| irq | output | 1 | Group-complete interrupt |

## Verification
The assertions assume that software leaves the start address and ring length unchanged while capture runs. They also assume the ring length is a nonzero multiple of four. Otherwise the address-range property would compare against a moving window. The stimulus sets these two registers once, before enabling capture, and uses a 24-byte ring so that wrap happens often. The byte-spacing property relies on one byte per cycle at most, which the port itself guarantees. The stimulus includes back-to-back valid bytes, so this spacing is exercised at its tightest.

// File: rtl/ts_ring_pkg.sv
package ts_ring_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_PACK = 1'b1
    } cap_state_e;

    localparam logic [REG_AW-1:0] RI_CTRL    = 4'd0;
    localparam logic [REG_AW-1:0] RI_BASE    = 4'd1;
    localparam logic [REG_AW-1:0] RI_RINGLEN = 4'd2;
    localparam logic [REG_AW-1:0] RI_PKTLEN  = 4'd3;
    localparam logic [REG_AW-1:0] RI_GROUP   = 4'd4;
    localparam logic [REG_AW-1:0] RI_WPTR    = 4'd5;
    localparam logic [REG_AW-1:0] RI_STATUS  = 4'd6;
    localparam logic [REG_AW-1:0] RI_MASK    = 4'd7;
    localparam logic [REG_AW-1:0] RI_RESTART = 4'd8;

endpackage

// File: rtl/ts_ring_regs.sv
module ts_ring_regs
    import ts_ring_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 24,
    parameter int CNT_W    = 16,
    parameter int RING_RST = 120320,
    parameter int PKT_RST  = 188,
    parameter int GRP_RST  = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ADDR_W-1:0] wptr,
    input  logic              status,
    output logic              en,
    output logic              mask,
    output logic [ADDR_W-1:0] base,
    output logic [LEN_W-1:0]  ring_len,
    output logic [CNT_W-1:0]  pkt_len,
    output logic [CNT_W-1:0]  group_cnt,
    output logic              restart,
    output logic              status_clr
);

    logic hit_ctrl, hit_base, hit_ring, hit_pkt, hit_grp, hit_mask;

    always_comb begin
        hit_ctrl   = reg_we && (reg_addr == RI_CTRL);
        hit_base   = reg_we && (reg_addr == RI_BASE);
        hit_ring   = reg_we && (reg_addr == RI_RINGLEN);
        hit_pkt    = reg_we && (reg_addr == RI_PKTLEN);
        hit_grp    = reg_we && (reg_addr == RI_GROUP);
        hit_mask   = reg_we && (reg_addr == RI_MASK);
        restart    = reg_we && (reg_addr == RI_RESTART) && reg_wdata[0];
        status_clr = reg_we && (reg_addr == RI_STATUS) && reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            mask      <= 1'b0;
            base      <= '0;
            ring_len  <= LEN_W'(RING_RST);
            pkt_len   <= CNT_W'(PKT_RST);
            group_cnt <= CNT_W'(GRP_RST);
        end else begin
            if (hit_ctrl) en        <= reg_wdata[0];
            if (hit_mask) mask      <= reg_wdata[0];
            if (hit_base) base      <= reg_wdata[ADDR_W-1:0];
            if (hit_ring) ring_len  <= reg_wdata[LEN_W-1:0];
            if (hit_pkt)  pkt_len   <= reg_wdata[CNT_W-1:0];
            if (hit_grp)  group_cnt <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr)
            RI_CTRL:    reg_rdata = {31'd0, en};
            RI_BASE:    reg_rdata = 32'(base);
            RI_RINGLEN: reg_rdata = 32'(ring_len);
            RI_PKTLEN:  reg_rdata = 32'(pkt_len);
            RI_GROUP:   reg_rdata = 32'(group_cnt);
            RI_WPTR:    reg_rdata = 32'(wptr);
            RI_STATUS:  reg_rdata = {31'd0, status};
            RI_MASK:    reg_rdata = {31'd0, mask};
            default:    reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/ts_ring_packer.sv
module ts_ring_packer
    import ts_ring_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] pkt_len,
    input  logic             ts_valid,
    input  logic             ts_start,
    input  logic [7:0]       ts_data,
    output logic             word_valid,
    output logic [31:0]      word_data,
    output logic             pkt_done
);

    cap_state_e       state_q, state_d;
    logic [CNT_W-1:0] byte_cnt_q, count_now;
    logic [1:0]       lane_q;
    logic [31:0]      hold_q;
    logic             accept;

    always_comb begin
        accept    = en && !restart && ts_valid && (ts_start || (state_q == ST_PACK));
        count_now = ts_start ? CNT_W'(1) : byte_cnt_q + CNT_W'(1);
        pkt_done  = accept && (count_now == pkt_len);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (accept && !pkt_done) state_d = ST_PACK;
            ST_PACK: if (accept && pkt_done)  state_d = ST_HUNT;
        endcase
        if (restart) state_d = ST_HUNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        word_data = hold_q;
        word_data[{lane_q, 3'b000} +: 8] = ts_data;
        word_valid = accept && (lane_q == 2'd3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt_q <= '0;
            lane_q     <= '0;
            hold_q     <= '0;
        end else if (restart) begin
            byte_cnt_q <= '0;
            lane_q     <= '0;
            hold_q     <= '0;
        end else if (accept) begin
            byte_cnt_q <= pkt_done ? '0 : count_now;
            lane_q     <= lane_q + 2'd1;
            hold_q     <= (lane_q == 2'd3) ? 32'd0 : word_data;
        end
    end

endmodule

// File: rtl/ts_ring_addr.sv
module ts_ring_addr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  ring_len,
    input  logic              word_valid,
    input  logic [31:0]       word_data,
    output logic [ADDR_W-1:0] wptr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);

    logic [LEN_W-1:0] off_q;
    logic [LEN_W:0]   step;
    logic             wrap;

    always_comb begin
        step = {1'b0, off_q} + (LEN_W+1)'(4);
        wrap = step >= {1'b0, ring_len};
        wptr = base + ADDR_W'(off_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= word_valid;
            if (restart) begin
                off_q <= '0;
            end else if (word_valid) begin
                mem_addr  <= wptr;
                mem_wdata <= word_data;
                off_q     <= wrap ? '0 : step[LEN_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ts_ring_irq.sv
module ts_ring_irq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pkt_done,
    input  logic [CNT_W-1:0] group_cnt,
    input  logic             status_clr,
    output logic             status
);

    logic [CNT_W-1:0] pkt_cnt_q, pkt_next;
    logic             group_hit;

    always_comb begin
        pkt_next  = pkt_cnt_q + CNT_W'(1);
        group_hit = pkt_done && (pkt_next >= group_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_cnt_q <= '0;
            status    <= 1'b0;
        end else begin
            if (restart)        pkt_cnt_q <= '0;
            else if (group_hit) pkt_cnt_q <= '0;
            else if (pkt_done)  pkt_cnt_q <= pkt_next;

            if (group_hit)       status <= 1'b1;
            else if (status_clr) status <= 1'b0;
        end
    end

endmodule

// File: rtl/ts_ring_writer.sv
module ts_ring_writer
    import ts_ring_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 24,
    parameter int CNT_W    = 16,
    parameter int RING_RST = 120320,
    parameter int PKT_RST  = 188,
    parameter int GRP_RST  = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ts_valid,
    input  logic              ts_start,
    input  logic [7:0]        ts_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              irq
);

    logic              en, mask, restart, status_clr, status;
    logic [ADDR_W-1:0] base, wptr;
    logic [LEN_W-1:0]  ring_len;
    logic [CNT_W-1:0]  pkt_len, group_cnt;
    logic              word_valid, pkt_done;
    logic [31:0]       word_data;

    ts_ring_regs #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
        .RING_RST(RING_RST), .PKT_RST(PKT_RST), .GRP_RST(GRP_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wptr(wptr),
        .status(status), .en(en), .mask(mask), .base(base),
        .ring_len(ring_len), .pkt_len(pkt_len), .group_cnt(group_cnt),
        .restart(restart), .status_clr(status_clr)
    );

    ts_ring_packer #(.CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(restart),
        .pkt_len(pkt_len), .ts_valid(ts_valid), .ts_start(ts_start),
        .ts_data(ts_data), .word_valid(word_valid), .word_data(word_data),
        .pkt_done(pkt_done)
    );

    ts_ring_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .base(base),
        .ring_len(ring_len), .word_valid(word_valid), .word_data(word_data),
        .wptr(wptr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    ts_ring_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .pkt_done(pkt_done),
        .group_cnt(group_cnt), .status_clr(status_clr), .status(status)
    );

    assign irq = status && mask && en;

endmodule

// File: rtl/ts_ring_chk.sv
module ts_ring_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ts_valid,
    input logic              en,
    input logic              restart,
    input logic              status,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] base,
    input logic [LEN_W-1:0]  ring_len,
    input logic [ADDR_W-1:0] wptr
);

    // R2
    word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R3
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ADDR_W'(mem_addr - base) < ADDR_W'(ring_len)));

    // R11
    write_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(en));

    // R7
    status_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> ($past(ts_valid) && $past(en)));

    // R10
    restart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (wptr == base));

endmodule

bind ts_ring_writer ts_ring_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .en(en),
    .restart(restart), .status(status), .mem_we(mem_we),
    .mem_addr(mem_addr), .base(base), .ring_len(ring_len), .wptr(wptr)
);

// File: tb/ts_ring_writer_test.sv
module ts_ring_writer_test;

    localparam logic [3:0] A_CTRL = 4'd0, A_BASE = 4'd1, A_RING = 4'd2,
                           A_PKT = 4'd3, A_GRP = 4'd4, A_WPTR = 4'd5,
                           A_STAT = 4'd6, A_MASK = 4'd7, A_RST = 4'd8;
    localparam int BASE = 32'h1000;
    localparam int RING = 24;
    localparam int PKT  = 8;
    localparam int GRP  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ts_valid = 1'b0, ts_start = 1'b0;
    logic [7:0]  ts_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [63:0] exp_q[$];

    // reference model state
    bit          m_en = 0, m_inpkt = 0, m_status = 0;
    int          m_lane = 0, m_off = 0, m_cnt = 0, m_pkts = 0;
    logic [31:0] m_word = '0;

    always #5 clk = ~clk;

    ts_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ts_valid(ts_valid),
        .ts_start(ts_start), .ts_data(ts_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every memory write (R2, R3)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected write", {mem_addr, mem_wdata}, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R2/R3 write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ts_valid = 1'b0; ts_start = 1'b0;
        end
    endtask

    // driver: applies one byte and pushes the expected memory word
    task automatic put(input logic [7:0] d, input bit st);
        int cnt;
        @(negedge clk); ts_valid = 1'b1; ts_data = d; ts_start = st;
        if (m_en && (st || m_inpkt)) begin
            cnt = st ? 1 : m_cnt + 1;
            m_word[8*m_lane +: 8] = d;
            if (m_lane == 3) begin
                exp_q.push_back({32'(BASE + m_off), m_word});
                m_off += 4;
                if (m_off >= RING) m_off = 0;
                m_word = '0;
                m_lane = 0;
            end else begin
                m_lane++;
            end
            if (cnt == PKT) begin
                m_inpkt = 0; m_cnt = 0; m_pkts++;
                if (m_pkts >= GRP) begin m_status = 1; m_pkts = 0; end
            end else begin
                m_inpkt = 1; m_cnt = cnt;
            end
        end
    endtask

    task automatic packet(input logic [7:0] seed, input int len);
        for (int i = 0; i < len; i++) put(seed + 8'(i * 7), i == 0);
        idle(3);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
        rd(A_RING, v); check(v == 120320, "R1 ring", v, 120320);
        rd(A_PKT, v);  check(v == 188, "R1 pktlen", v, 188);
        rd(A_GRP, v);  check(v == 47, "R1 group", v, 47);
        rd(A_WPTR, v); check(v == 0, "R1 wptr", v, 0);
        rd(A_STAT, v); check(v == 0, "R1 status", v, 0);
        check(irq == 0 && mem_we == 0, "R1 outputs", {irq, mem_we}, 0);

        wr(A_BASE, BASE); wr(A_RING, RING); wr(A_PKT, PKT); wr(A_GRP, GRP);
        wr(A_MASK, 1); wr(A_CTRL, 1); m_en = 1;
        rd(A_WPTR, v); check(v == BASE, "R4 wptr at start", v, BASE);

        // R5: bytes before any start are dropped
        put(8'hAA, 0); put(8'hBB, 0); put(8'hCC, 0); put(8'hDD, 0); put(8'hEE, 0);
        idle(3);
        rd(A_WPTR, v); check(v == BASE, "R5 no movement in hunt", v, BASE);

        // R2 R4: first packet
        packet(8'h10, PKT);
        rd(A_WPTR, v); check(v == BASE + 8, "R4 wptr after packet", v, BASE + 8);
        rd(A_STAT, v); check(v == 0, "R7 status after 1 packet", v, 0);

        // R7 R8: second packet completes the group
        packet(8'h40, PKT);
        rd(A_STAT, v); check(v == 1, "R7 status after group", v, 1);
        check(irq == 1, "R8 irq high", irq, 1);
        wr(A_MASK, 0); #1;
        check(irq == 0, "R8 irq masked", irq, 0);
        wr(A_MASK, 1);

        // R9 write-one-to-clear
        wr(A_STAT, 0);
        rd(A_STAT, v); check(v == 1, "R9 write zero keeps", v, 1);
        wr(A_STAT, 1); m_status = 0;
        rd(A_STAT, v); check(v == 0, "R9 write one clears", v, 0);
        #1 check(irq == 0, "R8 irq after clear", irq, 0);

        // R3 wrap: offsets 16, 20 then back to 0
        packet(8'h70, PKT);
        rd(A_WPTR, v); check(v == BASE, "R3 wrap to start", v, BASE);

        // R6 resync: 5 bytes, then a new start plus 3 bytes
        for (int i = 0; i < 5; i++) put(8'h90 + 8'(i), i == 0);
        for (int i = 0; i < 4; i++) put(8'hA0 + 8'(i), i == 0);
        idle(3);
        rd(A_STAT, v); check(v == 0, "R6 resync no completion", v, 0);
        for (int i = 0; i < 4; i++) put(8'hB0 + 8'(i), 0);
        idle(3);
        rd(A_STAT, v); check(v == 1, "R6 resynced packet completes", v, 1);
        wr(A_STAT, 1); m_status = 0;

        // R10 restart
        put(8'hC0, 1); put(8'hC1, 0); idle(2);
        wr(A_RST, 1);
        m_off = 0; m_lane = 0; m_word = '0; m_inpkt = 0; m_cnt = 0; m_pkts = 0;
        rd(A_WPTR, v); check(v == BASE, "R10 restart pointer", v, BASE);
        put(8'hC2, 0); put(8'hC3, 0); put(8'hC4, 0); put(8'hC5, 0); idle(3);
        rd(A_WPTR, v); check(v == BASE, "R10 hunt after restart", v, BASE);
        packet(8'h22, PKT);
        rd(A_WPTR, v); check(v == BASE + 8, "R10 fresh packing", v, BASE + 8);

        // R11 disable gates capture
        wr(A_CTRL, 0); m_en = 0;
        packet(8'h55, PKT); packet(8'h66, PKT);
        rd(A_WPTR, v); check(v == BASE + 8, "R11 pointer frozen", v, BASE + 8);
        rd(A_STAT, v); check(v == 0, "R11 status unchanged", v, 0);
        wr(A_CTRL, 1); m_en = 1;
        packet(8'h33, PKT);
        rd(A_STAT, v); check(v == 1, "R7 group after re-enable", v, 1);
        wr(A_CTRL, 0); #1;
        check(irq == 0, "R11 irq gated by enable", irq, 0);
        idle(4);

        check(exp_q.size() == 0, "R2 all words written", 64'(exp_q.size()), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule